// File: doc/BRIEF.md
# Register-Write Command Stream Packer

This block turns a stream of register write requests into a packed command buffer held in a local word-addressed RAM. Each request carries a register offset, a 32-bit value and a flag that selects a direct write or an indexed (auto-increment) write. A direct write becomes one two-word instruction. Indexed writes become counted burst instructions: a run of indexed writes to the same register shares a single header, and the packer raises the burst's count word in place for each extra value.

When the producer has queued a batch it pulses the flush input. The packer fills the space from the free pointer up to the next 64-byte boundary with zero words, one word per cycle. It then pulses a done strobe with the tail byte offset and empties itself for the next batch. A later fetch engine reads the buffer through a combinational read port. Requests that would spill past the buffer's capacity are dropped, and a sticky overflow flag is raised.

Top module: `regwr_packer`

## Requirements
- R1: An accepted direct write (`req_indexed`=0) stores the value at the free pointer P and the header {8'h01, 4'hF, offset[19:0]} at P+1, with no alignment of P, and moves the free pointer to P+2.
- R2: An accepted indexed write whose offset differs from the open burst's register, or made with no burst open, first rounds P up to an even word index A. It then stores the count 1 at A, the header {8'h09, 4'h0, offset[19:0]} at A+1 and the value at A+2, moves the free pointer to A+3 and opens a burst on that register starting at A.
- R3: An accepted indexed write to the open burst's register stores the value at P, adds one to the count word at the burst start, and moves the free pointer to P+1.
- R4: A direct write closes the open burst, and so does a completed flush. A following indexed write to the same register therefore starts a new burst with count 1.
- R5: After every accepted indexed write that leaves the free pointer odd, the word at the free pointer reads zero.
- R6: A request is dropped, with no word changed, when any word it would write (the pad word included) lies at or beyond `BUF_WORDS`. `overflow` then goes high and stays high until a flush completes.
- R7: A flush with a non-empty buffer writes zeros from P up to T-1, where T is P rounded up to a multiple of 16 words. It then pulses `flush_done` for exactly one cycle with `tail_bytes` = 4*T.
- R8: The flush that pulses `flush_done` also resets the free pointer and the burst start to zero, so the next accepted write lands at word 0.
- R9: A flush with an empty buffer has no effect: no `flush_done` pulse, and `req_ready` returns high once `flush_req` drops.
- R10: `req_ready` is low in any cycle where `flush_req` is high (a flush takes priority over a request) and in every cycle of flush padding. A request is accepted only when `req_valid` and `req_ready` are both high.
- R11: `rd_data` gives, in the same cycle, the buffer word at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Packer can take a request this cycle |
| req_offset | input | 20 | Register offset of the request |
| req_data | input | 32 | Value to write |
| req_indexed | input | 1 | 1 = indexed (burst) write, 0 = direct write |
| flush_req | input | 1 | Close the batch: pad and report the tail |
| flush_done | output | 1 | One-cycle strobe at the end of a flush |
| tail_bytes | output | FILL_W+2 | Tail byte offset, valid with `flush_done` |
| overflow | output | 1 | Sticky: a request was dropped for lack of space |
| rd_addr | input | AW | Buffer read address |
| rd_data | output | 32 | Buffer word at `rd_addr` |

## Verification
If the free pointer goes wrong, the next instruction lands at the wrong address, and the first buffer sweep after the following flush shows the misplaced or zeroed words. The tail also comes out off by a cacheline in the same `flush_done` cycle. A stale burst start or register makes the next merge patch the wrong count word, or fail to merge, and this is visible in the words of that batch. Errors in the sequencing state show up on `req_ready` or `flush_done` in the very cycle they occur, because the bench reference model predicts both on every clock.

// File: rtl/regwr_pkg.sv
`timescale 1ns/1ps
package regwr_pkg;
    localparam int WORD_W = 32;
    localparam int OFFS_W = 20;
    localparam int NSLOT  = 4;

    localparam logic [7:0] OPC_DIRECT = 8'h01;
    localparam logic [7:0] OPC_BURST  = 8'h09;
    localparam logic [3:0] LANES_ALL  = 4'hF;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OFFS_W-1:0] offs_t;

    typedef enum logic {PK_RUN, PK_PAD} pk_state_e;

    // Up to NSLOT consecutive word writes starting at one base address
    typedef struct packed {
        logic [NSLOT-1:0]  en;
        word_t [NSLOT-1:0] data;
    } slot_bundle_t;

    function automatic word_t direct_header(offs_t o);
        return {OPC_DIRECT, LANES_ALL, o};
    endfunction

    function automatic word_t burst_header(offs_t o);
        return {OPC_BURST, 4'h0, o};
    endfunction
endpackage

// File: rtl/regwr_planner.sv
`timescale 1ns/1ps
module regwr_planner
    import regwr_pkg::*;
#(
    parameter int BUF_WORDS = 2048,
    parameter int FILL_W    = 12
) (
    input  logic [FILL_W-1:0] fill,
    input  logic              open_vld,
    input  offs_t             open_reg,
    input  offs_t             req_offset,
    input  word_t             req_data,
    input  logic              req_indexed,
    output logic              merge,
    output logic              fits,
    output logic [FILL_W-1:0] base,
    output logic [FILL_W-1:0] next_fill,
    output slot_bundle_t      slots
);
    localparam int EXT_W = FILL_W + 2;

    logic [EXT_W-1:0] fill_x, even_x, base_x, end_x, top_x;

    always_comb begin
        fill_x = EXT_W'(fill);
        even_x = fill_x + EXT_W'(fill[0]);
        merge  = req_indexed && open_vld && (open_reg == req_offset);
        slots  = '0;
        if (!req_indexed) begin
            // value, then header; no alignment
            base_x        = fill_x;
            slots.en      = NSLOT'(4'b0011);
            slots.data[0] = req_data;
            slots.data[1] = direct_header(req_offset);
            end_x         = fill_x + EXT_W'(2);
            top_x         = end_x;
        end else if (merge) begin
            // append value; pad the following word if the pointer turns odd
            base_x        = fill_x;
            slots.en[0]   = 1'b1;
            slots.data[0] = req_data;
            slots.en[1]   = ~fill[0];
            slots.data[1] = '0;
            end_x         = fill_x + EXT_W'(1);
            top_x         = fill[0] ? end_x : fill_x + EXT_W'(2);
        end else begin
            // new burst at an even word: count, header, value, pad
            base_x        = even_x;
            slots.en      = NSLOT'(4'b1111);
            slots.data[0] = word_t'(1);
            slots.data[1] = burst_header(req_offset);
            slots.data[2] = req_data;
            slots.data[3] = '0;
            end_x         = even_x + EXT_W'(3);
            top_x         = even_x + EXT_W'(4);
        end
        fits      = (top_x <= EXT_W'(BUF_WORDS));
        base      = FILL_W'(base_x);
        next_fill = FILL_W'(end_x);
    end
endmodule

// File: rtl/regwr_buffer.sv
`timescale 1ns/1ps
module regwr_buffer
    import regwr_pkg::*;
#(
    parameter int BUF_WORDS = 2048,
    parameter int AW        = 11
) (
    input  logic         clk,
    input  logic [AW-1:0] wr_base,
    input  slot_bundle_t  slots,
    input  logic          inc_en,
    input  logic [AW-1:0] inc_addr,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_data
);
    word_t mem [BUF_WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (slots.en[i]) mem[wr_base + AW'(i)] <= slots.data[i];
        end
        // count patch never overlaps the slot window (start < free pointer)
        if (inc_en) mem[inc_addr] <= mem[inc_addr] + word_t'(1);
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/regwr_ctrl.sv
`timescale 1ns/1ps
module regwr_ctrl
    import regwr_pkg::*;
#(
    parameter int BUF_WORDS  = 2048,
    parameter int LINE_WORDS = 16,
    parameter int FILL_W     = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              flush_req,
    input  logic              req_indexed,
    input  offs_t             req_offset,
    input  logic              merge,
    input  logic              fits,
    input  logic [FILL_W-1:0] next_fill,
    input  logic [FILL_W-1:0] new_start,
    output logic              req_ready,
    output logic              accept,
    output logic [FILL_W-1:0] fill,
    output logic              open_vld,
    output offs_t             open_reg,
    output logic [FILL_W-1:0] start,
    output logic              pad_wr,
    output logic [FILL_W-1:0] pad_ptr,
    output logic              pad_active,
    output logic              flush_done,
    output logic [FILL_W+1:0] tail_bytes,
    output logic              overflow
);
    localparam int EXT_W = FILL_W + 1;

    pk_state_e         state;
    logic [FILL_W-1:0] tail_w;
    logic [EXT_W-1:0]  sum_x, rnd_x;

    always_comb begin
        sum_x = EXT_W'(fill) + EXT_W'(LINE_WORDS - 1);
        rnd_x = sum_x & ~EXT_W'(LINE_WORDS - 1);
    end

    assign req_ready  = (state == PK_RUN) && !flush_req;
    assign accept     = req_valid && req_ready && fits;
    assign pad_active = (state == PK_PAD);
    assign pad_wr     = pad_active && (pad_ptr != tail_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PK_RUN;
            fill       <= '0;
            open_vld   <= 1'b0;
            open_reg   <= '0;
            start      <= '0;
            pad_ptr    <= '0;
            tail_w     <= '0;
            flush_done <= 1'b0;
            tail_bytes <= '0;
            overflow   <= 1'b0;
        end else begin
            flush_done <= 1'b0;
            case (state)
                PK_RUN: begin
                    if (flush_req) begin
                        if (fill != '0) begin
                            state   <= PK_PAD;
                            pad_ptr <= fill;
                            tail_w  <= FILL_W'(rnd_x);
                        end
                    end else if (req_valid) begin
                        if (fits) begin
                            fill <= next_fill;
                            if (!req_indexed) begin
                                open_vld <= 1'b0;
                            end else begin
                                open_vld <= 1'b1;
                                open_reg <= req_offset;
                                if (!merge) start <= new_start;
                            end
                        end else begin
                            overflow <= 1'b1;
                        end
                    end
                end
                PK_PAD: begin
                    if (pad_ptr == tail_w) begin
                        flush_done <= 1'b1;
                        tail_bytes <= {tail_w, 2'b00};
                        fill       <= '0;
                        open_vld   <= 1'b0;
                        start      <= '0;
                        overflow   <= 1'b0;
                        state      <= PK_RUN;
                    end else begin
                        pad_ptr <= pad_ptr + FILL_W'(1);
                    end
                end
                default: state <= PK_RUN;
            endcase
        end
    end
endmodule

// File: rtl/regwr_packer.sv
`timescale 1ns/1ps
module regwr_packer
    import regwr_pkg::*;
#(
    parameter int BUF_WORDS  = 2048,
    parameter int LINE_BYTES = 64,
    localparam int FILL_W    = $clog2(BUF_WORDS + 1),
    localparam int AW        = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [19:0]       req_offset,
    input  logic [31:0]       req_data,
    input  logic              req_indexed,
    input  logic              flush_req,
    output logic              flush_done,
    output logic [FILL_W+1:0] tail_bytes,
    output logic              overflow,
    input  logic [AW-1:0]     rd_addr,
    output logic [31:0]       rd_data
);
    localparam int LINE_WORDS = LINE_BYTES / 4;

    logic              merge, fits, accept, open_vld, pad_wr, pad_active;
    logic [FILL_W-1:0] fill, start, pad_ptr, plan_base, next_fill;
    offs_t             open_reg;
    slot_bundle_t      plan_slots, wr_slots;
    logic [AW-1:0]     wr_base;

    regwr_planner #(.BUF_WORDS(BUF_WORDS), .FILL_W(FILL_W)) u_plan (
        .fill(fill), .open_vld(open_vld), .open_reg(open_reg),
        .req_offset(req_offset), .req_data(req_data), .req_indexed(req_indexed),
        .merge(merge), .fits(fits), .base(plan_base), .next_fill(next_fill),
        .slots(plan_slots)
    );

    regwr_ctrl #(.BUF_WORDS(BUF_WORDS), .LINE_WORDS(LINE_WORDS), .FILL_W(FILL_W)) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .flush_req(flush_req),
        .req_indexed(req_indexed), .req_offset(req_offset), .merge(merge),
        .fits(fits), .next_fill(next_fill), .new_start(plan_base),
        .req_ready(req_ready), .accept(accept), .fill(fill),
        .open_vld(open_vld), .open_reg(open_reg), .start(start),
        .pad_wr(pad_wr), .pad_ptr(pad_ptr), .pad_active(pad_active),
        .flush_done(flush_done), .tail_bytes(tail_bytes), .overflow(overflow)
    );

    always_comb begin
        wr_slots = '0;
        wr_base  = AW'(plan_base);
        if (pad_wr) begin
            wr_base     = AW'(pad_ptr);
            wr_slots.en = NSLOT'(1);
        end else if (accept) begin
            wr_slots = plan_slots;
        end
    end

    regwr_buffer #(.BUF_WORDS(BUF_WORDS), .AW(AW)) u_buf (
        .clk(clk), .wr_base(wr_base), .slots(wr_slots),
        .inc_en(accept && merge), .inc_addr(AW'(start)),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/regwr_packer_chk.sv
`timescale 1ns/1ps
module regwr_packer_chk #(
    parameter int BUF_WORDS  = 2048,
    parameter int LINE_BYTES = 64,
    parameter int FILL_W     = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              flush_req,
    input logic              flush_done,
    input logic [FILL_W+1:0] tail_bytes,
    input logic              overflow,
    input logic [FILL_W-1:0] fill,
    input logic              pad_active
);
    // R7: done is a single-cycle strobe
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done);

    // R7: reported tail is a whole, non-zero number of cachelines
    a_r7_tail_aligned: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> (tail_bytes % LINE_BYTES == 0) && (tail_bytes != '0));

    // R6: overflow only falls together with a flush completion
    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> (overflow || flush_done));

    // R6: the free pointer never passes the capacity
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_W'(BUF_WORDS));

    // R8: buffer is empty right after a completed flush
    a_r8_fill_cleared: assert property (@(posedge clk) disable iff (rst)
        flush_done |-> fill == '0);

    // R10: no request taken during padding
    a_r10_no_ready_pad: assert property (@(posedge clk) disable iff (rst)
        pad_active |-> !req_ready);

    // R9: empty flush neither pads nor signals completion
    a_r9_empty_flush: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !pad_active && fill == '0) |=> (!pad_active && !flush_done));
endmodule

bind regwr_packer regwr_packer_chk #(
    .BUF_WORDS(BUF_WORDS), .LINE_BYTES(LINE_BYTES), .FILL_W(FILL_W)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .flush_req(flush_req),
    .flush_done(flush_done), .tail_bytes(tail_bytes), .overflow(overflow),
    .fill(fill), .pad_active(pad_active)
);

// File: tb/test_regwr_packer.sv
`timescale 1ns/1ps
module test_regwr_packer;
    localparam int BUF_WORDS = 2048;
    localparam int FILL_W    = $clog2(BUF_WORDS + 1);
    localparam int AW        = $clog2(BUF_WORDS);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_indexed = 1'b0, flush_req = 1'b0;
    logic              req_ready, flush_done, overflow;
    logic [19:0]       req_offset = '0;
    logic [31:0]       req_data = '0, rd_data;
    logic [FILL_W+1:0] tail_bytes;
    logic [AW-1:0]     rd_addr = '0;

    regwr_packer #(.BUF_WORDS(BUF_WORDS), .LINE_BYTES(64)) i_regwr_packer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_data(req_data), .req_indexed(req_indexed),
        .flush_req(flush_req), .flush_done(flush_done), .tail_bytes(tail_bytes),
        .overflow(overflow), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_mem [BUF_WORDS];
    int  m_fill = 0, m_start = 0, m_ptr = 0, m_tailw = 0, m_tail = 0;
    int  m_reg = 0;
    bit  m_open = 0, m_pad = 0, m_done = 0, m_ovf = 0;

    task automatic model_step(bit v, bit f, logic [19:0] off, logic [31:0] val, bit idx);
        bit done_n = 0;
        if (m_pad) begin
            if (m_ptr == m_tailw) begin
                done_n = 1; m_tail = m_tailw * 4;
                m_fill = 0; m_start = 0; m_open = 0; m_ovf = 0; m_pad = 0;
            end else begin
                m_mem[m_ptr] = 32'h0; m_ptr++;
            end
        end else if (f) begin
            if (m_fill != 0) begin
                m_pad = 1; m_ptr = m_fill; m_tailw = ((m_fill + 15) / 16) * 16;
            end
        end else if (v) begin
            if (!idx) begin
                if (m_fill + 2 <= BUF_WORDS) begin
                    m_mem[m_fill] = val;
                    m_mem[m_fill+1] = {8'h01, 4'hF, off};
                    m_fill += 2; m_open = 0;
                end else m_ovf = 1;
            end else if (m_open && m_reg == int'(off)) begin
                if (m_fill + ((m_fill % 2 == 0) ? 2 : 1) <= BUF_WORDS) begin
                    m_mem[m_fill] = val;
                    m_mem[m_start] = m_mem[m_start] + 32'd1;
                    m_fill++;
                    if (m_fill % 2 == 1) m_mem[m_fill] = 32'h0;
                end else m_ovf = 1;
            end else begin
                int a = m_fill + (m_fill % 2);
                if (a + 4 <= BUF_WORDS) begin
                    m_mem[a] = 32'd1;
                    m_mem[a+1] = {8'h09, 4'h0, off};
                    m_mem[a+2] = val;
                    m_mem[a+3] = 32'h0;
                    m_start = a; m_fill = a + 3; m_open = 1; m_reg = int'(off);
                end else m_ovf = 1;
            end
        end
        m_done = done_n;
    endtask

    // one clock: compare registered outputs, drive inputs, compare ready, step model
    task automatic cyc(bit v, bit f, logic [19:0] off, logic [31:0] val, bit idx);
        @(negedge clk);
        chk(flush_done === m_done, "R7", "flush_done", longint'(flush_done), longint'(m_done));
        if (m_done)
            chk(tail_bytes === (FILL_W+2)'(m_tail), "R7", "tail_bytes", longint'(tail_bytes), longint'(m_tail));
        chk(overflow === m_ovf, "R6", "overflow", longint'(overflow), longint'(m_ovf));
        req_valid = v; flush_req = f; req_offset = off; req_data = val; req_indexed = idx;
        #1;
        chk(req_ready === (!m_pad && !f), "R10", "req_ready", longint'(req_ready), longint'(!m_pad && !f));
        model_step(v, f, off, val, idx);
    endtask

    task automatic idle();
        cyc(0, 0, 20'h0, 32'h0, 0);
    endtask

    task automatic wr(logic [19:0] off, logic [31:0] val, bit idx);
        cyc(1, 0, off, val, idx);
    endtask

    task automatic flush_all();
        cyc(0, 1, 20'h0, 32'h0, 0);
        while (m_pad) idle();
        idle();
    endtask

    task automatic sweep(int n, string tag);
        for (int i = 0; i < n; i++) begin
            rd_addr = AW'(i);
            #1;
            chk(rd_data === m_mem[i], tag, $sformatf("word %0d", i), longint'(rd_data), longint'(m_mem[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < BUF_WORDS; i++) m_mem[i] = 'x;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // reset state (R10, R6, R7)
        #1;
        chk(req_ready === 1'b1, "R10", "ready after reset", longint'(req_ready), 1);
        chk(flush_done === 1'b0, "R7", "done after reset", longint'(flush_done), 0);
        chk(overflow === 1'b0, "R6", "overflow after reset", longint'(overflow), 0);

        // R1 / R11: direct writes, no alignment, value before header
        wr(20'h12345, 32'hDEADBEEF, 0);
        wr(20'h00010, 32'h00000001, 0);
        wr(20'hABCDE, 32'h55AA55AA, 1);
        wr(20'h00777, 32'h0BADF00D, 0);   // direct at odd pointer
        flush_all();
        sweep(m_tail / 4, "R1");
        chk(m_tail == 64, "R7", "model tail one line", longint'(m_tail), 64);

        // R2 / R3: merged burst then a new burst on another register
        wr(20'h00100, 32'h11111111, 1);
        wr(20'h00100, 32'h22222222, 1);
        wr(20'h00100, 32'h33333333, 1);
        wr(20'h00200, 32'h44444444, 1);
        wr(20'h00200, 32'h55555555, 1);
        flush_all();
        sweep(m_tail / 4, "R3");
        rd_addr = '0; #1;
        chk(rd_data === 32'd3, "R3", "burst count", longint'(rd_data), 3);
        rd_addr = AW'(6); #1;
        chk(rd_data === 32'd2, "R2", "second burst count at even word", longint'(rd_data), 2);

        // R4: direct closes burst; flush closes burst
        wr(20'h00300, 32'hA0000001, 1);
        wr(20'h00300, 32'hA0000002, 0);
        wr(20'h00300, 32'hA0000003, 1);
        flush_all();
        sweep(m_tail / 4, "R4");
        wr(20'h00300, 32'hA0000004, 1);
        flush_all();
        sweep(m_tail / 4, "R4");
        rd_addr = '0; #1;
        chk(rd_data === 32'd1, "R4", "count after flush", longint'(rd_data), 1);

        // R5: pad word must overwrite old content
        for (int i = 0; i < 8; i++) wr(20'h00400 + 20'(i), 32'hCAFE0000 + 32'(i), 0);
        flush_all();
        sweep(m_tail / 4, "R7");
        wr(20'h00500, 32'hB0000001, 1);
        wr(20'h00600, 32'hB0000002, 1);
        wr(20'h00600, 32'hB0000003, 1);
        flush_all();
        sweep(m_tail / 4, "R5");
        rd_addr = AW'(3); #1;
        chk(rd_data === 32'h0, "R5", "pad word 3", longint'(rd_data), 0);

        // R10: flush wins over a simultaneous request; requests during padding refused
        wr(20'h00700, 32'hC0000001, 0);
        cyc(1, 1, 20'h00701, 32'hC0000002, 0);
        while (m_pad) wr(20'h00702, 32'hC0000003, 0);
        idle();
        sweep(m_tail / 4, "R10");

        // R9: empty flush
        cyc(0, 1, 20'h0, 32'h0, 0);
        idle(); idle();
        chk(flush_done === 1'b0 && req_ready === 1'b1, "R9", "empty flush",
            longint'({flush_done, req_ready}), 1);

        // R6: fill to capacity, then drop
        for (int i = 0; i < BUF_WORDS / 2; i++) wr(20'(i), 32'(i * 7 + 1), 0);
        wr(20'hFFFFF, 32'hEEEEEEEE, 0);
        wr(20'hFFFFE, 32'hDDDDDDDD, 1);
        idle();
        chk(overflow === 1'b1, "R6", "overflow raised", longint'(overflow), 1);
        flush_all();
        chk(m_tail == BUF_WORDS * 4, "R6", "full tail", longint'(m_tail), BUF_WORDS * 4);
        sweep(BUF_WORDS, "R6");
        idle();
        chk(overflow === 1'b0, "R6", "overflow cleared by flush", longint'(overflow), 0);

        // R8: next write lands at word 0
        wr(20'h00042, 32'h87654321, 0);
        flush_all();
        sweep(m_tail / 4, "R8");
        rd_addr = '0; #1;
        chk(rd_data === 32'h87654321, "R8", "word 0 after flush", longint'(rd_data), 32'h87654321);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule